// File: doc/BRIEF.md
# Serial DAC Control Front End

This block is the digital front end of a 12-bit voltage-output converter. A host writes 16-bit words over a three-wire serial link: an active-low frame strobe, a serial clock and a data line. The block captures each word and splits it into a 2-bit termination mode and a 12-bit conversion code. It holds both in registers and drives the code value together with one-hot controls that pick the output termination. The analog string, the amplifier and the switches that these controls drive are outside the block.

The serial pins are asynchronous to the block clock. They pass through synchronizers. Edges of the serial clock and the frame strobe are then detected in the clock domain, so the system clock must run several times faster than the serial clock. A word takes effect only once all sixteen bits have arrived. A power-down word changes only the termination. The held code survives it and is still present when a normal-mode word later restores drive.

Top module: `sdac_front`

## Requirements
- R1: After a synchronous reset the code output is 0, the termination is normal drive (term_drive=1, the three other selects 0) and pd_active is 0.
- R2: A word is 16 bits, shifted in most significant bit first. One bit is taken on each falling edge of sclk while sync_n is low. Bits 11..0 of a normal-mode word (bits 13:12 = 00) become the code output.
- R3: Bits 13:12 pick the termination: 00 selects term_drive, 01 selects term_1k, 10 selects term_100k and 11 selects term_hiz. Exactly one of the four selects is high at any time.
- R4: pd_active is high exactly when the held mode is not 00. term_hiz is high only for mode 11.
- R5: A word whose mode field is not 00 updates only the mode. The code register keeps its earlier value through any power-down. A later word with mode 00 loads its own code.
- R6: Bits 15:14 of a word have no effect on any output.
- R7: If sync_n rises before 16 bits have been taken, the word is discarded and neither the code nor the mode changes.
- R8: sync_n may stay low across a pause in sclk, for example between two 8-bit transfers. The bits on both sides of the pause form one 16-bit word.
- R9: Code and mode change together, in the same cycle, only after the 16th falling sclk edge. Falling edges after the 16th are ignored until the next frame.
- R10: A falling edge of sync_n clears the bit count and starts a new word, discarding any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Frame strobe, active low, asynchronous |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdin | input | 1 | Serial data, most significant bit first |
| dac_code | output | 12 | Held conversion code |
| pd_active | output | 1 | High in any power-down mode |
| term_drive | output | 1 | Normal output drive selected |
| term_1k | output | 1 | 1k pull-down to ground selected |
| term_100k | output | 1 | 100k pull-down to ground selected |
| term_hiz | output | 1 | High-impedance output selected |

## Verification
The assertions check, on every cycle, that exactly one termination select is high and that pd_active agrees with it. They also check that the bit count never passes sixteen, that a frame start clears it, and that the registers change only in the cycle after a completed word. A further assertion checks that a power-down word leaves the code untouched. Only the bench scenarios can show the bit order, the field positions and the ignored top bits. The same holds for discarding a short or restarted frame, joining a split transfer, and ignoring clock edges past the sixteenth bit, since each of these depends on the serial stimulus that comes before it.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int FRAME_W  = 16;
    localparam int CODE_W   = 12;
    localparam int MODE_LSB = 12;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        TERM_DRIVE = 2'b00,
        TERM_1K    = 2'b01,
        TERM_100K  = 2'b10,
        TERM_HIZ   = 2'b11
    } term_mode_e;

    typedef struct packed {
        term_mode_e        mode;
        logic [CODE_W-1:0] code;
    } ctrl_word_t;

    typedef struct packed {
        logic drive;
        logic r1k;
        logic r100k;
        logic hiz;
    } term_sel_t;

    function automatic ctrl_word_t unpack_frame(input logic [FRAME_W-1:0] f);
        ctrl_word_t r;
        r.mode = term_mode_e'(f[MODE_LSB+MODE_W-1:MODE_LSB]);
        r.code = f[CODE_W-1:0];
        return r;
    endfunction

    function automatic term_sel_t term_decode(input term_mode_e m);
        term_sel_t s;
        s = '0;
        case (m)
            TERM_DRIVE: s.drive = 1'b1;
            TERM_1K:    s.r1k   = 1'b1;
            TERM_100K:  s.r100k = 1'b1;
            default:    s.hiz   = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg  <= {STAGES{RST_VAL}};
            prev <= RST_VAL;
        end else begin
            stg[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
            prev <= stg[STAGES-1];
        end
    end

    assign cur = stg[STAGES-1];

endmodule

// File: rtl/sdac_shift_rx.sv
module sdac_shift_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  logic               bit_strobe,
    input  logic               bit_in,
    output logic               word_valid,
    output logic [FRAME_W-1:0] word
);

    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            shreg      <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (frame_start) begin
                cnt <= '0;
            end else if (bit_strobe && (cnt < CNT_FULL)) begin
                shreg <= {shreg[FRAME_W-2:0], bit_in};
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_LAST) begin
                    word_valid <= 1'b1;
                end
            end
        end
    end

    assign word = shreg;

    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_FULL);

    a_r9_valid_full: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (cnt == CNT_FULL));

    a_r10_restart_clears: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cnt == '0 && !word_valid));

endmodule

// File: rtl/sdac_ctrl_regs.sv
module sdac_ctrl_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  ctrl_word_t        wr_word,
    output logic [CODE_W-1:0] code,
    output term_sel_t         sel,
    output logic              pd
);

    term_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code   <= '0;
            mode_q <= TERM_DRIVE;
        end else if (load) begin
            mode_q <= wr_word.mode;
            if (wr_word.mode == TERM_DRIVE) begin
                code <= wr_word.code;
            end
        end
    end

    assign sel = term_decode(mode_q);
    assign pd  = (mode_q != TERM_DRIVE);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (code == '0 && mode_q == TERM_DRIVE));

    a_r3_one_term: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);

    a_r4_pd_vs_drive: assert property (@(posedge clk) disable iff (rst)
        pd == !sel.drive);

    a_r5_code_held: assert property (@(posedge clk) disable iff (rst)
        (load && wr_word.mode != TERM_DRIVE) |=> $stable(code));

    a_r9_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(code) && $stable(mode_q)));

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic [CODE_W-1:0] dac_code,
    output logic              pd_active,
    output logic              term_drive,
    output logic              term_1k,
    output logic              term_100k,
    output logic              term_hiz
);

    localparam int PIN_SYNC = 2;
    localparam int PIN_SCLK = 1;
    localparam int PIN_DATA = 0;

    logic [2:0]         pin_cur;
    logic [2:0]         pin_prev;
    logic               frame_start;
    logic               bit_strobe;
    logic               word_valid;
    logic [FRAME_W-1:0] word;
    term_sel_t          sel;

    sdac_pin_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_pins (
        .clk  (clk),
        .rst  (rst),
        .raw  ({sync_n, sclk, sdin}),
        .cur  (pin_cur),
        .prev (pin_prev)
    );

    assign frame_start = pin_prev[PIN_SYNC] && !pin_cur[PIN_SYNC];
    assign bit_strobe  = !pin_cur[PIN_SYNC] && pin_prev[PIN_SCLK] && !pin_cur[PIN_SCLK];

    sdac_shift_rx #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bit_strobe  (bit_strobe),
        .bit_in      (pin_cur[PIN_DATA]),
        .word_valid  (word_valid),
        .word        (word)
    );

    sdac_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .load    (word_valid),
        .wr_word (unpack_frame(word)),
        .code    (dac_code),
        .sel     (sel),
        .pd      (pd_active)
    );

    assign term_drive = sel.drive;
    assign term_1k    = sel.r1k;
    assign term_100k  = sel.r100k;
    assign term_hiz   = sel.hiz;

    a_r7_no_load_sync_high: assert property (@(posedge clk) disable iff (rst)
        pin_cur[PIN_SYNC] |=> !word_valid);

endmodule

// File: tb/test_sdac_front.sv
module test_sdac_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdin = 1'b0;
    logic [11:0] dac_code;
    logic        pd_active, term_drive, term_1k, term_100k, term_hiz;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [11:0] exp_code = '0;
    logic [1:0]  exp_mode = 2'b00;

    always #4 clk = ~clk;

    sdac_front i_sdac_front (
        .clk        (clk),
        .rst        (rst),
        .sync_n     (sync_n),
        .sclk       (sclk),
        .sdin       (sdin),
        .dac_code   (dac_code),
        .pd_active  (pd_active),
        .term_drive (term_drive),
        .term_1k    (term_1k),
        .term_100k  (term_100k),
        .term_hiz   (term_hiz)
    );

    function automatic logic [3:0] exp_sel(input logic [1:0] m);
        case (m)
            2'b00:   return 4'b1000;
            2'b01:   return 4'b0100;
            2'b10:   return 4'b0010;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic void model_apply(input logic [15:0] w);
        exp_mode = w[13:12];
        if (w[13:12] == 2'b00) exp_code = w[11:0];
    endfunction

    task automatic clk_wait(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_outputs(input string req);
        @(negedge clk);
        n_tests++;
        if (dac_code !== exp_code) begin
            n_fail++;
            $display("FAIL %s code: actual %h expected %h", req, dac_code, exp_code);
        end
        n_tests++;
        if ({term_drive, term_1k, term_100k, term_hiz} !== exp_sel(exp_mode) ||
            pd_active !== (exp_mode != 2'b00)) begin
            n_fail++;
            $display("FAIL %s term/pd: actual %b/%b expected %b/%b", req,
                     {term_drive, term_1k, term_100k, term_hiz}, pd_active,
                     exp_sel(exp_mode), (exp_mode != 2'b00));
        end
        #1;
    endtask

    task automatic start_frame();
        sync_n = 1'b0;
        clk_wait(6);
    endtask

    task automatic end_frame();
        clk_wait(4);
        sync_n = 1'b1;
        clk_wait(8);
    endtask

    task automatic shift_bit(input logic b);
        sdin = b;
        clk_wait(4);
        sclk = 1'b0;
        clk_wait(4);
        sclk = 1'b1;
    endtask

    task automatic send_bits(input logic [15:0] w, input int nbits, input bit split);
        for (int i = 15; i >= 16 - nbits; i--) begin
            shift_bit(w[i]);
            if (split && i == 8) clk_wait(24);
        end
    endtask

    task automatic send_word(input logic [15:0] w, input bit split);
        start_frame();
        send_bits(w, 16, split);
        end_frame();
        model_apply(w);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5DAC_0121));
        clk_wait(5);
        rst = 1'b0;
        clk_wait(4);

        check_outputs("R1 reset");

        send_word(16'h0ABC, 1'b0);
        check_outputs("R2 normal load");

        send_word(16'h1555, 1'b0);
        check_outputs("R3 R5 mode 1k keeps code");
        send_word(16'h2777, 1'b0);
        check_outputs("R3 R5 mode 100k keeps code");
        send_word(16'h3FFF, 1'b0);
        check_outputs("R3 R4 mode hiz");

        send_word(16'h0321, 1'b0);
        check_outputs("R5 return to normal loads code");

        send_word(16'hC123, 1'b0);
        check_outputs("R6 top bits ignored");
        send_word(16'h8000, 1'b0);
        check_outputs("R6 top bits ignored zero code");

        start_frame();
        send_bits(16'h0F0F, 10, 1'b0);
        end_frame();
        check_outputs("R7 short frame discarded");

        start_frame();
        send_bits(16'h0DEF, 15, 1'b0);
        clk_wait(12);
        check_outputs("R9 no update after 15 edges");
        shift_bit(1'b1);
        clk_wait(8);
        model_apply(16'h0DEF);
        check_outputs("R9 update after 16th edge");
        send_bits(16'h2000, 4, 1'b0);
        end_frame();
        check_outputs("R9 extra edges ignored");

        start_frame();
        send_bits(16'h0AAA, 7, 1'b0);
        sync_n = 1'b1;
        clk_wait(4);
        start_frame();
        send_bits(16'h0456, 16, 1'b0);
        end_frame();
        model_apply(16'h0456);
        check_outputs("R10 restart discards partial");

        send_word(16'h0B7C, 1'b1);
        check_outputs("R8 split transfer");

        for (int k = 0; k < 60; k++) begin
            logic [15:0] w;
            int          nb;
            bit          sp;
            w  = 16'($urandom);
            nb = ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 15)) : 16;
            sp = $urandom_range(0, 2) == 0;
            start_frame();
            send_bits(w, nb, sp && nb == 16);
            end_frame();
            if (nb == 16) begin
                model_apply(w);
                check_outputs("R2 R3 R5 R6 random word");
            end else begin
                check_outputs("R7 random short frame");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule